// File: doc/BRIEF.md
# Serial Flash Deep Power-Down Command Controller

This block is the slave-side command front end of a serial memory, limited to the two power commands. The pins of the serial interface are oversampled by a fast system clock: an active-low select, a serial clock, a data input, and a data output that can be released to high impedance. The block shifts in an instruction byte. It can send the memory into a deep power-down state or bring it back. The wake command also returns a one-byte identification value.

A sleep command takes effect only when the select line rises exactly after its eighth bit. The block then spends a set number of system cycles in a transition state before it reports deep power-down. The wake command is followed by 24 don't-care address bits, and after them the identification byte is shifted out, repeated for as long as the select line stays low.

The wake command ends in one of two ways. If at least one full identification byte was clocked out, the block returns to standby at once. If the select line rises earlier, the block returns to standby only after a second timed transition. The wake command is refused while the busy input reports an erase, program or status write. Delays and the identification byte are parameters.

Top module: `flash_pd_ctrl`

## Requirements
- R1: After reset the block reports standby (standby_o=1, deep_pd_o=0, trans_o=0), and miso_oe_o is 0.
- R2: Input bits are taken on rising serial clock edges, MSB of the opcode first. Output bits change on falling edges, MSB first. The identification byte is the parameter SIG_BYTE (default 8'h10).
- R3: From standby, opcode 8'hB9 followed by a select rise after exactly 8 bits sets trans_o for T_DP system cycles. After that, deep_pd_o is set.
- R4: Opcode 8'hB9 with the select rising after any bit count other than 8 leaves the mode unchanged.
- R5: In deep power-down, every opcode except 8'hAB leaves the mode unchanged and keeps miso_oe_o at 0.
- R6: After opcode 8'hAB come 24 ignored bits. From the falling edge after bit 32 on, the output carries SIG_BYTE MSB first, repeating every 8 bits while the select stays low.
- R7: From deep power-down, an accepted 8'hAB frame with at least 40 bits returns the block to standby immediately on deselect, with no transition state.
- R8: From deep power-down, an accepted 8'hAB frame ended after 8 to 39 bits sets trans_o for T_RES system cycles. After that, standby is set.
- R9: In standby, 8'hAB returns the identification byte and leaves the mode at standby.
- R10: While busy_i is 1, 8'hAB is refused: miso_oe_o stays 0 and the mode is unchanged.
- R11: A frame whose eighth bit arrives while trans_o is 1 is ignored.
- R12: miso_oe_o is 0 while the select is high, and whenever no identification bit is being driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System oversampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Serial select, active low |
| sck_i | input | 1 | Serial clock |
| mosi_i | input | 1 | Serial data in |
| busy_i | input | 1 | Erase, program or status write in progress |
| miso_o | output | 1 | Serial data out value |
| miso_oe_o | output | 1 | Drive enable for miso_o (0 = high impedance) |
| standby_o | output | 1 | Mode is standby |
| deep_pd_o | output | 1 | Mode is deep power-down |
| trans_o | output | 1 | An entry or release delay is running |

## Verification
The assertions assume that busy_i does not change while the select is low. They also assume serial clock phases several system cycles long, so that every pin edge passes the two-flop synchronizer. With those assumptions, the output is never enabled during a busy cycle or a transition. The stimulus sets busy only between frames and holds it for the whole frame. It uses serial half-periods of six system cycles. It waits out the longest delay before it starts a new frame, except in the directed case that deliberately lands a frame inside a transition.

// File: rtl/flash_pd_pkg.sv
`timescale 1ns/1ps
package flash_pd_pkg;
  typedef enum logic [1:0] {
    MODE_STBY  = 2'd0,
    MODE_ENTER = 2'd1,
    MODE_DPD   = 2'd2,
    MODE_REL   = 2'd3
  } mode_e;

  localparam logic [7:0] OP_SLEEP = 8'hB9;
  localparam logic [7:0] OP_WAKE  = 8'hAB;
  localparam int unsigned OP_BITS    = 8;
  localparam int unsigned DUMMY_BITS = 24;
  localparam int unsigned SIG_BITS   = 8;
  localparam int unsigned SIG_START  = OP_BITS + DUMMY_BITS;
  localparam int unsigned FRAME_BITS = SIG_START + SIG_BITS;
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 1);
endpackage

// File: rtl/pin_sync.sv
`timescale 1ns/1ps
module pin_sync #(
  parameter int unsigned W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= RST_VAL[g];
        s2_q <= RST_VAL[g];
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/frame_rx.sv
`timescale 1ns/1ps
module frame_rx
  import flash_pd_pkg::*;
#(
  parameter logic [7:0] SIG_BYTE = 8'h10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_s_i,
  input  logic             sck_rise_i,
  input  logic             sck_fall_i,
  input  logic             mosi_s_i,
  input  logic             busy_i,
  input  mode_e            mode_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             sleep_ok_o,
  output logic             wake_ok_o,
  output logic             bit_o,
  output logic             drive_o
);
  localparam logic [CNT_W-1:0] LAST_OP  = CNT_W'(OP_BITS - 1);
  localparam logic [CNT_W-1:0] OPC_DONE = CNT_W'(OP_BITS);
  localparam logic [CNT_W-1:0] SIG_BEG  = CNT_W'(SIG_START);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_BITS);

  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       sr_q;
  logic [7:0]       opc_nxt;
  logic [2:0]       idx_q;
  logic             sleep_q, wake_q, bit_q, drv_q;

  assign opc_nxt = {sr_q[6:0], mosi_s_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      sr_q    <= '0;
      idx_q   <= '0;
      sleep_q <= 1'b0;
      wake_q  <= 1'b0;
      bit_q   <= 1'b0;
      drv_q   <= 1'b0;
    end else if (cs_s_i) begin
      cnt_q   <= '0;
      idx_q   <= '0;
      sleep_q <= 1'b0;
      wake_q  <= 1'b0;
      bit_q   <= 1'b0;
      drv_q   <= 1'b0;
    end else begin
      if (sck_rise_i) begin
        if (cnt_q < CNT_MAX) cnt_q <= cnt_q + 1'b1;
        if (cnt_q < OPC_DONE) sr_q <= opc_nxt;
        // decode at the eighth bit against the mode current at that moment
        if (cnt_q == LAST_OP) begin
          sleep_q <= (opc_nxt == OP_SLEEP) && (mode_i == MODE_STBY);
          wake_q  <= (opc_nxt == OP_WAKE) && !busy_i &&
                     ((mode_i == MODE_STBY) || (mode_i == MODE_DPD));
        end
      end
      if (sck_fall_i && wake_q && (cnt_q >= SIG_BEG)) begin
        bit_q <= SIG_BYTE[3'd7 - idx_q];
        idx_q <= idx_q + 1'b1;
        drv_q <= 1'b1;
      end
    end
  end

  assign cnt_o      = cnt_q;
  assign sleep_ok_o = sleep_q;
  assign wake_ok_o  = wake_q;
  assign bit_o      = bit_q;
  assign drive_o    = drv_q;
endmodule

// File: rtl/pwr_mode_fsm.sv
`timescale 1ns/1ps
module pwr_mode_fsm
  import flash_pd_pkg::*;
#(
  parameter int unsigned T_DP  = 200,
  parameter int unsigned T_RES = 300
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_rise_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             sleep_ok_i,
  input  logic             wake_ok_i,
  output mode_e            mode_o
);
  localparam int unsigned T_MAX = (T_DP > T_RES) ? T_DP : T_RES;
  localparam int unsigned TW    = $clog2(T_MAX + 1);
  localparam logic [TW-1:0] LD_DP  = TW'(T_DP - 1);
  localparam logic [TW-1:0] LD_RES = TW'(T_RES - 1);
  localparam logic [CNT_W-1:0] OPC_DONE = CNT_W'(OP_BITS);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_BITS);

  mode_e          mode_q, mode_d;
  logic [TW-1:0]  tmr_q, tmr_d;

  always_comb begin
    mode_d = mode_q;
    tmr_d  = tmr_q;
    unique case (mode_q)
      MODE_STBY: begin
        if (cs_rise_i && sleep_ok_i && (cnt_i == OPC_DONE)) begin
          mode_d = MODE_ENTER;
          tmr_d  = LD_DP;
        end
      end
      MODE_DPD: begin
        if (cs_rise_i && wake_ok_i) begin
          if (cnt_i == CNT_MAX) begin
            mode_d = MODE_STBY;
          end else begin
            mode_d = MODE_REL;
            tmr_d  = LD_RES;
          end
        end
      end
      MODE_ENTER, MODE_REL: begin
        if (tmr_q == '0) mode_d = (mode_q == MODE_ENTER) ? MODE_DPD : MODE_STBY;
        else             tmr_d  = tmr_q - 1'b1;
      end
      default: mode_d = MODE_STBY;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_STBY;
      tmr_q  <= '0;
    end else begin
      mode_q <= mode_d;
      tmr_q  <= tmr_d;
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/flash_pd_ctrl.sv
`timescale 1ns/1ps
module flash_pd_ctrl
  import flash_pd_pkg::*;
#(
  parameter logic [7:0]  SIG_BYTE = 8'h10,
  parameter int unsigned T_DP     = 200,
  parameter int unsigned T_RES    = 300
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic mosi_i,
  input  logic busy_i,
  output logic miso_o,
  output logic miso_oe_o,
  output logic standby_o,
  output logic deep_pd_o,
  output logic trans_o
);
  logic [2:0]       pins_s;
  logic             cs_s, sck_s, mosi_s;
  logic             cs_q, sck_q;
  logic             sck_rise, sck_fall, cs_rise;
  logic [CNT_W-1:0] cnt;
  logic             sleep_ok, wake_ok, drive;
  mode_e            mode;

  pin_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sck_i, mosi_i}),
    .q_o   (pins_s)
  );
  assign {cs_s, sck_s, mosi_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q  <= 1'b1;
      sck_q <= 1'b0;
    end else begin
      cs_q  <= cs_s;
      sck_q <= sck_s;
    end
  end

  assign sck_rise = sck_s & ~sck_q & ~cs_s;
  assign sck_fall = ~sck_s & sck_q & ~cs_s;
  assign cs_rise  = cs_s & ~cs_q;

  frame_rx #(.SIG_BYTE(SIG_BYTE)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_s_i    (cs_s),
    .sck_rise_i(sck_rise),
    .sck_fall_i(sck_fall),
    .mosi_s_i  (mosi_s),
    .busy_i    (busy_i),
    .mode_i    (mode),
    .cnt_o     (cnt),
    .sleep_ok_o(sleep_ok),
    .wake_ok_o (wake_ok),
    .bit_o     (miso_o),
    .drive_o   (drive)
  );

  pwr_mode_fsm #(.T_DP(T_DP), .T_RES(T_RES)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_rise_i (cs_rise),
    .cnt_i     (cnt),
    .sleep_ok_i(sleep_ok),
    .wake_ok_i (wake_ok),
    .mode_o    (mode)
  );

  assign miso_oe_o = drive & ~cs_s;
  assign standby_o = (mode == MODE_STBY);
  assign deep_pd_o = (mode == MODE_DPD);
  assign trans_o   = (mode == MODE_ENTER) || (mode == MODE_REL);
endmodule

// File: rtl/flash_pd_ctrl_chk.sv
`timescale 1ns/1ps
module flash_pd_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_ni,
  input logic busy_i,
  input logic miso_oe_o,
  input logic standby_o,
  input logic deep_pd_o,
  input logic trans_o
);
  // R3: deep power-down is reached only through the entry delay
  a_r3_deep_after_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(deep_pd_o) |-> $past(trans_o));

  // R8: standby is reached from a delay or directly from deep power-down
  a_r8_standby_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(standby_o) |-> ($past(trans_o) || $past(deep_pd_o)));

  // R10: no output drive during a busy write cycle
  a_r10_busy_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miso_oe_o |-> !busy_i);

  // R11: no output drive while a delay runs
  a_r11_trans_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miso_oe_o |-> !trans_o);

  // R12: output released once the deselect has crossed the synchronizer
  a_r12_hiz_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni) && $past(cs_ni, 2)) |-> !miso_oe_o);

  // R1: exactly one mode indication at any time
  a_r1_one_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot({standby_o, deep_pd_o, trans_o}));
endmodule

bind flash_pd_ctrl flash_pd_ctrl_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_ni    (cs_ni),
  .busy_i   (busy_i),
  .miso_oe_o(miso_oe_o),
  .standby_o(standby_o),
  .deep_pd_o(deep_pd_o),
  .trans_o  (trans_o)
);

// File: tb/flash_pd_ctrl_test.sv
`timescale 1ns/1ps
module flash_pd_ctrl_test;
  localparam logic [7:0] SIG = 8'h10;
  localparam int TDP  = 200;
  localparam int TRES = 300;
  localparam int H    = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, busy = 1'b0;
  logic miso, miso_oe, stby, deep, trans;
  int   n_chk = 0, n_fail = 0;
  bit   finished = 1'b0;

  always #4 clk = ~clk;

  flash_pd_ctrl #(.SIG_BYTE(SIG), .T_DP(TDP), .T_RES(TRES)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .mosi_i(mosi),
    .busy_i(busy), .miso_o(miso), .miso_oe_o(miso_oe), .standby_o(stby),
    .deep_pd_o(deep), .trans_o(trans)
  );

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // mode code: 0 standby, 1 deep, 2 transition
  function automatic int mode_now();
    return trans ? 2 : (deep ? 1 : (stby ? 0 : 3));
  endfunction

  function automatic int settled_mode(int m, logic [7:0] op, int nb, bit bz);
    if (m == 0) return (op == 8'hB9 && nb == 8) ? 1 : 0;
    return (op == 8'hAB && !bz && nb >= 8) ? 0 : 1;
  endfunction

  function automatic bit wake_taken(logic [7:0] op, int nb, bit bz);
    return op == 8'hAB && !bz && nb >= 8;
  endfunction

  // drive one frame; count driven signature bits, mismatches, stray drives
  task automatic frame(input logic [7:0] op, input int nb,
                       output int drv, output int bad_bit, output int stray);
    drv = 0; bad_bit = 0; stray = 0;
    cs_n = 1'b0;
    cyc(H);
    for (int i = 0; i < nb; i++) begin
      sck  = 1'b0;
      mosi = (i < 8) ? op[7-i] : 1'($urandom % 2);
      cyc(H);
      if (i >= 32) begin
        if (miso_oe) begin
          drv++;
          if (miso !== SIG[7-((i-32)%8)]) bad_bit++;
        end
      end else if (miso_oe) stray++;
      sck = 1'b1;
      cyc(H);
    end
    sck = 1'b0;
    cyc(H);
    cs_n = 1'b1;
  endtask

  int d, b, s;

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R1
    check("R1 mode", mode_now(), 0);
    check("R1 oe", miso_oe, 0);

    // R4: wrong length sleep
    frame(8'hB9, 7, d, b, s);  cyc(TRES + 20);
    check("R4 7 bits", mode_now(), 0);
    frame(8'hB9, 9, d, b, s);  cyc(TRES + 20);
    check("R4 9 bits", mode_now(), 0);

    // R9, R6, R2: wake from standby, two signature bytes
    frame(8'hAB, 48, d, b, s); cyc(6);
    check("R9 mode", mode_now(), 0);
    check("R6 drive count", d, 16);
    check("R2 sig bits", b, 0);
    check("R12 no early drive", s, 0);

    // R3: sleep enters via delay
    frame(8'hB9, 8, d, b, s); cyc(6);
    check("R3 trans", mode_now(), 2);
    // R11: wake frame during entry delay ignored
    frame(8'hAB, 8, d, b, s);
    cyc(TDP);
    check("R11 still deep", mode_now(), 1);

    // R5: other opcode in deep, full length
    frame(8'h9F, 48, d, b, s); cyc(6);
    check("R5 mode", mode_now(), 1);
    check("R5 no drive", d + s, 0);

    // R10: busy wake refused
    busy = 1'b1;
    frame(8'hAB, 48, d, b, s); cyc(6);
    check("R10 no drive", d + s, 0);
    check("R10 mode", mode_now(), 1);
    busy = 1'b0;
    cyc(4);

    // R7: full signature read releases at once
    frame(8'hAB, 40, d, b, s); cyc(6);
    check("R7 immediate", mode_now(), 0);
    check("R7 sig", b, 0);
    check("R12 released", miso_oe, 0);

    // R8: short wake uses release delay
    frame(8'hB9, 8, d, b, s); cyc(TDP + 20);
    check("R3 deep", mode_now(), 1);
    frame(8'hAB, 20, d, b, s); cyc(6);
    check("R8 trans", mode_now(), 2);
    cyc(TRES - 20);
    check("R8 still trans", mode_now(), 2);
    cyc(30);
    check("R8 standby", mode_now(), 0);

    // random mix
    void'($urandom(32'd1234));
    for (int k = 0; k < 40; k++) begin
      int lens[7] = '{7, 8, 9, 16, 33, 40, 45};
      logic [7:0] op;
      int nb, m0, em;
      bit bz;
      case ($urandom % 4)
        0, 1: op = 8'hB9;
        2:    op = 8'hAB;
        default: op = 8'($urandom);
      endcase
      if ($urandom % 3 == 0) op = 8'hAB;
      nb = lens[$urandom % 7];
      bz = ($urandom % 4 == 0);
      m0 = mode_now();
      busy = bz;
      frame(op, nb, d, b, s);
      cyc(TRES + 20);
      busy = 1'b0;
      em = settled_mode(m0, op, nb, bz);
      check("R3/R4/R5/R7/R8/R10 rand mode", mode_now(), em);
      check("R6 rand drive", d,
            (wake_taken(op, nb, bz) && nb > 32) ? nb - 32 : 0);
      check("R2 rand sig", b, 0);
      check("R12 rand stray", s, 0);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule